// File: doc/BRIEF.md
# Thermal hysteresis test-session controller

This block runs the test of a single core under a thermal ceiling. It reads a temperature sample, an upper trip level and a lower resume level. It keeps the core in one of three states: waiting, testing or done. While testing, it lets patterns through. When the sample reaches the upper level, it halts the sub-sequence, hands the core's bus bandwidth back and waits for passive cooling. It offers the core for test again only once the sample has fallen to the resume level. In this way one test set is cut into sub-sequences with cooling gaps between them. The very first sub-sequence may begin from a temperature below the resume level.

An external bandwidth allocator watches the ready request and answers with a start grant. The pattern source pulses a strobe for each pattern applied. The controller loads the size of the test set while reset is held. It counts patterns down internally and keeps the remaining count across every cooling gap. The remaining count reaches zero only when the final pattern of the set has been applied. Temperature estimation, bus transport and the choice of the resume level are left to the surrounding logic.

Top module: `thermal_session_ctrl`

## Requirements
- R1: While rst is high, and in the first cycle after it, state_o is 0, pat_en_o is 0, bw_release_o is 0 and ready_req_o is 0. The pattern count is loaded from pat_total_i while rst is high.
- R2: state_o encodes waiting as 0, testing as 1 and done as 2. From waiting, the core moves to testing at a clock edge only if start_test_i is 1, temp_i is at or below cl_i, and the remaining count is nonzero. Otherwise it stays waiting, which includes the case where temp_i is above cl_i while the grant is high.
- R3: In testing, the state holds at every edge where temp_i is below tl_i and the last pattern is not being strobed.
- R4: In testing, an edge with temp_i at or above tl_i and no final strobe moves the core to waiting, with pat_en_o low from then on. The core then stays waiting, even with a grant, while temp_i is above cl_i.
- R5: In testing, a strobe while the remaining count is 1 moves the core to done. Done holds for all inputs until reset.
- R6: When the final strobe and temp_i at or above tl_i occur at the same edge, the core goes to done, not to waiting.
- R7: bw_release_o is high for exactly the one cycle after each edge that leaves testing, for either exit, and is low at all other times.
- R8: ready_req_o is registered. After an edge, it is 1 exactly when the new state is waiting, temp_i at that edge was at or below cl_i, and the remaining count is nonzero.
- R9: The remaining count drops by one per pat_strobe_i in testing only. Strobes in waiting or done are ignored, and the count is kept through cooling.
- R10: If the remaining count is zero while waiting (pat_total_i = 0), the core moves to done at the next edge, with no bw_release_o pulse.
- R11: pat_en_o is 1 exactly in the cycles where state_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the pattern count |
| temp_i | input | TEMP_W | Unsigned fixed-point core temperature sample |
| tl_i | input | TEMP_W | Upper trip level |
| cl_i | input | TEMP_W | Lower resume level |
| start_test_i | input | 1 | Grant from the bandwidth allocator |
| pat_strobe_i | input | 1 | One pulse per pattern applied |
| pat_total_i | input | CNT_W | Test-set size, sampled during reset |
| state_o | output | 2 | 0 waiting, 1 testing, 2 done |
| pat_en_o | output | 1 | Pattern application enable |
| bw_release_o | output | 1 | One-cycle bandwidth hand-back pulse |
| ready_req_o | output | 1 | Request to be scheduled for test |

## Verification
Every output is a flop that updates at the same edge as the state. The effect of the inputs presented before an edge is therefore due in the cycle right after that edge, with no further delay. The bench changes inputs at the falling edge and samples all four outputs one nanosecond after the next rising edge. The release pulse is checked again one cycle later to show that it has cleared. Ignored strobes and a count held through cooling are shown through the exact strobe on which the core reaches done.

// File: rtl/thermal_session_pkg.sv
package thermal_session_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_TEST = 2'd1,
    ST_DONE = 2'd2
  } sess_state_t;
endpackage

// File: rtl/tsc_thresholds.sv
module tsc_thresholds #(
  parameter int TEMP_W = 12
) (
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] tl_i,
  input  logic [TEMP_W-1:0] cl_i,
  output logic              cool_o,
  output logic              hot_o
);
  // Both comparisons are inclusive: reaching a level counts as crossing it.
  always_comb begin
    cool_o = (temp_i <= cl_i);
    hot_o  = (temp_i >= tl_i);
  end
endmodule

// File: rtl/tsc_pattern_counter.sv
module tsc_pattern_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] total_i,
  input  logic             dec_i,
  output logic             last_o,
  output logic             empty_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)        left_q <= total_i;
    else if (dec_i) left_q <= left_q - ONE;
  end

  always_comb begin
    last_o  = (left_q == ONE);
    empty_o = (left_q == '0);
  end

  // R9: a decrement never arrives with nothing left
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (rst)
    dec_i |-> !empty_o);

  // R9: without a decrement the count is held (e.g. through cooling)
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !dec_i |=> $stable(left_q));
endmodule

// File: rtl/tsc_fsm.sv
module tsc_fsm
  import thermal_session_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        cool_i,
  input  logic        hot_i,
  input  logic        strobe_i,
  input  logic        last_i,
  input  logic        empty_i,
  output logic        dec_o,
  output sess_state_t state_o,
  output logic        pat_en_o,
  output logic        rel_o,
  output logic        ready_o
);
  sess_state_t state_q, state_n;
  logic        pat_en_q, rel_q, ready_q;
  logic        final_pat, left_after;

  always_comb begin
    dec_o      = (state_q == ST_TEST) && strobe_i;
    final_pat  = dec_o && last_i;
    left_after = !empty_i && !final_pat;
  end

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_WAIT: begin
        if (empty_i)                state_n = ST_DONE;
        else if (start_i && cool_i) state_n = ST_TEST;
      end
      ST_TEST: begin
        // completion outranks the thermal trip
        if (final_pat)  state_n = ST_DONE;
        else if (hot_i) state_n = ST_WAIT;
      end
      ST_DONE: state_n = ST_DONE;
      default: state_n = ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_WAIT;
      pat_en_q <= 1'b0;
      rel_q    <= 1'b0;
      ready_q  <= 1'b0;
    end else begin
      state_q  <= state_n;
      pat_en_q <= (state_n == ST_TEST);
      rel_q    <= (state_q == ST_TEST) && (state_n != ST_TEST);
      ready_q  <= (state_n == ST_WAIT) && cool_i && left_after;
    end
  end

  always_comb begin
    state_o  = state_q;
    pat_en_o = pat_en_q;
    rel_o    = rel_q;
    ready_o  = ready_q;
  end

  // R2: no entry to testing without grant and a cool core
  assert_entry_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !(start_i && cool_i)) |=> (state_q != ST_TEST));

  // R3: testing persists while below the trip level and not finishing
  assert_stay_testing_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TEST && !hot_i && !(strobe_i && last_i)) |=> (state_q == ST_TEST));

  // R5: done is terminal
  assert_done_terminal_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |=> (state_q == ST_DONE));

  // R6: the final pattern wins over a simultaneous trip
  assert_finish_priority_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TEST && strobe_i && last_i) |=> (state_q == ST_DONE));

  // R7: release is a single-cycle pulse
  assert_release_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rel_q |=> !rel_q);

  // R8: a request is raised only by a waiting core
  assert_ready_waiting_R8: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> (state_q == ST_WAIT));

  // R11: pattern enable tracks the testing state
  assert_pat_en_R11: assert property (@(posedge clk) disable iff (rst)
    pat_en_q == (state_q == ST_TEST));
endmodule

// File: rtl/thermal_session_ctrl.sv
module thermal_session_ctrl
  import thermal_session_pkg::*;
#(
  parameter int TEMP_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] tl_i,
  input  logic [TEMP_W-1:0] cl_i,
  input  logic              start_test_i,
  input  logic              pat_strobe_i,
  input  logic [CNT_W-1:0]  pat_total_i,
  output logic [1:0]        state_o,
  output logic              pat_en_o,
  output logic              bw_release_o,
  output logic              ready_req_o
);
  logic        cool, hot, dec, last, empty;
  sess_state_t st;

  tsc_thresholds #(.TEMP_W(TEMP_W)) u_thr (
    .temp_i (temp_i),
    .tl_i   (tl_i),
    .cl_i   (cl_i),
    .cool_o (cool),
    .hot_o  (hot)
  );

  tsc_pattern_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .total_i (pat_total_i),
    .dec_i   (dec),
    .last_o  (last),
    .empty_o (empty)
  );

  tsc_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_test_i),
    .cool_i   (cool),
    .hot_i    (hot),
    .strobe_i (pat_strobe_i),
    .last_i   (last),
    .empty_i  (empty),
    .dec_o    (dec),
    .state_o  (st),
    .pat_en_o (pat_en_o),
    .rel_o    (bw_release_o),
    .ready_o  (ready_req_o)
  );

  assign state_o = st;

  // R4: a trip without completion lands in waiting
  assert_trip_to_wait_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && hot && !(pat_strobe_i && last)) |=> (state_o == 2'd0));

  // R10: an empty set never enters testing
  assert_empty_no_test_R10: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0 && empty) |=> (state_o == 2'd2 && !bw_release_o));
endmodule

// File: tb/thermal_session_ctrl_tb.sv
`timescale 1ns/1ps
module thermal_session_ctrl_tb;
  localparam int TEMP_W = 12;
  localparam int CNT_W  = 16;
  localparam logic [TEMP_W-1:0] TL = 12'd900;
  localparam logic [TEMP_W-1:0] CL = 12'd800;

  logic              clk = 1'b0;
  logic              rst;
  logic [TEMP_W-1:0] temp;
  logic              start, strobe;
  logic [CNT_W-1:0]  total;
  logic [1:0]        state;
  logic              pen, rel, rdy;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  thermal_session_ctrl #(.TEMP_W(TEMP_W), .CNT_W(CNT_W)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .temp_i       (temp),
    .tl_i         (TL),
    .cl_i         (CL),
    .start_test_i (start),
    .pat_strobe_i (strobe),
    .pat_total_i  (total),
    .state_o      (state),
    .pat_en_o     (pen),
    .bw_release_o (rel),
    .ready_req_o  (rdy)
  );

  // vector: temp[18:7] start[6] strobe[5] | exp state[4:3] pen[2] rel[1] ready[0]
  localparam int NV = 11;
  localparam logic [18:0] VEC [0:NV-1] = '{
    {12'd250, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1},
    {12'd250, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1},
    {12'd250, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0},
    {12'd500, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0},
    {12'd900, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
    {12'd850, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
    {12'd800, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1},
    {12'd800, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0},
    {12'd850, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0},
    {12'd900, 1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 1'b0},
    {12'd250, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 1'b0}
  };

  function automatic string vec_req(int i);
    case (i)
      0: vec_req = "R8 ready when cool";
      1: vec_req = "R9 strobe ignored while waiting";
      2: vec_req = "R2 first entry from ambient";
      3: vec_req = "R3 stay testing";
      4: vec_req = "R4 R7 trip at TL";
      5: vec_req = "R4 grant ignored above CL";
      6: vec_req = "R8 ready at CL";
      7: vec_req = "R2 resume at CL";
      8: vec_req = "R9 count held across cooling";
      9: vec_req = "R6 finish beats trip";
      default: vec_req = "R5 done is terminal";
    endcase
  endfunction

  task automatic check(string req, logic [1:0] es, logic ep, logic er, logic ey);
    checks++;
    if (state !== es || pen !== ep || rel !== er || rdy !== ey) begin
      errors++;
      $display("FAIL %s: actual st=%0d pen=%0b rel=%0b rdy=%0b expected st=%0d pen=%0b rel=%0b rdy=%0b",
               req, state, pen, rel, rdy, es, ep, er, ey);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(logic [TEMP_W-1:0] t, logic s, logic p,
                      string req, logic [1:0] es, logic ep, logic er, logic ey);
    temp = t; start = s; strobe = p;
    @(posedge clk); #1;
    check(req, es, ep, er, ey);
    @(negedge clk);
  endtask

  task automatic do_reset(logic [CNT_W-1:0] n);
    @(negedge clk);
    rst = 1'b1; total = n; temp = 12'd250; start = 1'b0; strobe = 1'b0;
    @(posedge clk); #1;
    check("R1 reset outputs", 2'd0, 1'b0, 1'b0, 1'b0);
    @(posedge clk); #1;
    check("R1 reset outputs held", 2'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; temp = 12'd250; start = 1'b0; strobe = 1'b0; total = 16'd3;

    // table walk with a three-pattern set
    do_reset(16'd3);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18:7], VEC[i][6], VEC[i][5], vec_req(i),
           VEC[i][4:3], VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R10: empty set goes straight to done without a release pulse
    do_reset(16'd0);
    step(12'd250, 1'b1, 1'b0, "R10 empty set done", 2'd2, 1'b0, 1'b0, 1'b0);
    step(12'd250, 1'b1, 1'b1, "R10 stays done", 2'd2, 1'b0, 1'b0, 1'b0);

    // R5 R7: single pattern completes below TL, release lasts one cycle
    do_reset(16'd1);
    step(12'd250, 1'b1, 1'b0, "R2 enter testing", 2'd1, 1'b1, 1'b0, 1'b0);
    step(12'd300, 1'b0, 1'b1, "R5 completion", 2'd2, 1'b0, 1'b1, 1'b0);
    step(12'd300, 1'b0, 1'b0, "R7 pulse cleared", 2'd2, 1'b0, 1'b0, 1'b0);

    // R2 R3 R4 R9 R11: longer run with a trip mid-set
    do_reset(16'd2);
    step(12'd850, 1'b1, 1'b0, "R2 grant refused above CL", 2'd0, 1'b0, 1'b0, 1'b0);
    step(12'd700, 1'b1, 1'b0, "R2 entry below CL", 2'd1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 20; k++) begin
      step(12'd500, 1'b0, 1'b0, "R3 R11 hold testing", 2'd1, 1'b1, 1'b0, 1'b0);
    end
    step(12'd899, 1'b0, 1'b0, "R3 just below TL", 2'd1, 1'b1, 1'b0, 1'b0);
    step(12'd905, 1'b0, 1'b1, "R4 trip with strobe counted", 2'd0, 1'b0, 1'b1, 1'b0);
    step(12'd880, 1'b1, 1'b1, "R9 strobe ignored while cooling", 2'd0, 1'b0, 1'b0, 1'b0);
    step(12'd790, 1'b0, 1'b0, "R8 ready after cooling", 2'd0, 1'b0, 1'b0, 1'b1);
    step(12'd790, 1'b1, 1'b0, "R2 resume", 2'd1, 1'b1, 1'b0, 1'b0);
    step(12'd600, 1'b0, 1'b1, "R9 last pattern finishes", 2'd2, 1'b0, 1'b1, 1'b0);
    step(12'd200, 1'b1, 1'b0, "R5 done holds", 2'd2, 1'b0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule